// File: doc/BRIEF.md
# Serial Link Bring-Up Controller

This block sequences a receiver through bringing up a point-to-point serial link with its companion transmitter. After reset the receiver sits in a low-power idle state. When an input signal appears and the clock-recovery loop reports lock, it announces itself to the transmitter over the back channel. It waits for the transmitter to acknowledge, then receives the training pattern and finally enters normal data transfer. The bring-up is a closed handshake: each step waits for an event from the other side or from the receive path.

If the signal disappears, the link is torn down to idle. If the signal is still present but lock is lost, the link falls back to detection, so it can be re-established without a full restart. Training is bounded by a programmable timeout. When line decoding is enabled, training completes only after the data-valid flag has been held high for a programmable number of consecutive cycles. With the back-channel handshake disabled, the controller goes straight from lock to normal transfer.

The analog back channel and the clock-recovery loop are outside the block. They appear here only as digital inputs and outputs.

Top module: `lnk_bringup_fsm`

## Requirements
- R1: While `rst_n` is low (asynchronous), the controller is in IDLE with `lock_n`=1, `lowpwr_req`=1 and `peer_present`=0.
- R2: `link_state` encodes IDLE=0, DETECT=1, ACQUIRE=2, NORMAL=3. `lowpwr_req` is 1 exactly in IDLE. `lock_n` is 0 exactly in NORMAL. `peer_present` is 1 exactly when `rsense_en` is 1 and the state is not IDLE.
- R3: IDLE is left only when `sig_det` and `cdr_lock` are both 1; with `rsense_en`=1 the next state is DETECT. `train_done` has no effect in IDLE or DETECT.
- R4: DETECT moves to ACQUIRE when `cdr_lock` and `peer_ack` are both 1; otherwise it stays in DETECT.
- R5: With `dec_en`=0, ACQUIRE moves to NORMAL in the cycle after `train_done` is 1.
- R6: From any non-IDLE state, `sig_det`=0 returns the controller to IDLE. With `sig_det`=1, `cdr_lock`=0 and `rsense_en`=1, it returns to DETECT.
- R7: With `rsense_en`=0, IDLE goes directly to NORMAL on signal plus lock. Any loss of signal or lock then returns to IDLE.
- R8: With `dec_en`=1, ACQUIRE completes only once `data_valid` has been 1 for DV_RUN consecutive ACQUIRE cycles (default 20) and `train_done` is 1. With `data_valid` held from entry, NORMAL is reached on the (DV_RUN+1)th clock.
- R9: If training is not complete, ACQUIRE returns to DETECT on the ACQ_TIMEOUT-th clock after entry (default 64).
- R10: Every state change takes effect on the first rising clock edge after its causing inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_det | input | 1 | Input signal detected |
| cdr_lock | input | 1 | Clock-recovery loop locked |
| peer_ack | input | 1 | Transmitter acknowledged receiver presence |
| train_done | input | 1 | Aligner has seen the complete training pattern |
| rsense_en | input | 1 | Back-channel handshake enabled |
| dec_en | input | 1 | Line decoding enabled (arms data-valid qualification) |
| data_valid | input | 1 | Decoded data-valid flag |
| link_state | output | 2 | Current state (0 IDLE, 1 DETECT, 2 ACQUIRE, 3 NORMAL) |
| lock_n | output | 1 | Active-low link-locked indication |
| lowpwr_req | output | 1 | Low-power request, high in IDLE |
| peer_present | output | 1 | Back-channel presence indication toward transmitter |

## Verification
The bound checker watches every cycle for four properties:
- IDLE is held while no signal is present.
- Loss of signal always leads to IDLE.
- ACQUIRE is entered only after an acknowledge, and NORMAL only after a completed pattern.
- The direct lock-to-NORMAL path is taken when the handshake is disabled.

Three things can only be shown by the bench's scenarios, which count clocks against the expected cycle:
- the exact length of the training timeout;
- the data-valid run needed under decoding;
- the fallback target chosen on lock loss.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_DETECT  = 2'd1,
      ST_ACQUIRE = 2'd2,
      ST_NORMAL  = 2'd3
   } lnk_state_t;

endpackage

// File: rtl/lnk_acq_timer.sv
module lnk_acq_timer #(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_acq,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("lnk_acq_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!in_acq) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = in_acq && (cnt_q == LAST);
endmodule

// File: rtl/lnk_dv_qual.sv
module lnk_dv_qual #(
   parameter int unsigned DV_RUN = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_acq,
   input  logic data_valid,
   output logic run_met
);
   generate
      if (DV_RUN == 0) begin : g_bypass
         assign run_met = 1'b1;
      end else begin : g_count
         localparam int unsigned RW = $clog2(DV_RUN + 1);
         localparam logic [RW-1:0] TOP = RW'(DV_RUN);
         logic [RW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (!in_acq || !data_valid) begin
               run_q <= '0;
            end else if (run_q != TOP) begin
               run_q <= run_q + 1'b1;
            end
         end

         assign run_met = (run_q == TOP);
      end
   endgenerate
endmodule

// File: rtl/lnk_next_state.sv
module lnk_next_state
   import lnk_pkg::*;
(
   input  lnk_state_t cur,
   input  logic       sig_det,
   input  logic       cdr_lock,
   input  logic       peer_ack,
   input  logic       rsense_en,
   input  logic       train_ok,
   input  logic       acq_expired,
   output lnk_state_t nxt
);
   always_comb begin
      nxt = cur;
      if (cur == ST_IDLE) begin
         if (sig_det && cdr_lock) begin
            nxt = rsense_en ? ST_DETECT : ST_NORMAL;
         end
      end else if (!sig_det) begin
         nxt = ST_IDLE;
      end else if (!cdr_lock) begin
         nxt = rsense_en ? ST_DETECT : ST_IDLE;
      end else if (!rsense_en && cur != ST_NORMAL) begin
         nxt = ST_IDLE;
      end else begin
         unique case (cur)
            ST_DETECT: begin
               if (peer_ack) nxt = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
               if (train_ok)         nxt = ST_NORMAL;
               else if (acq_expired) nxt = ST_DETECT;
            end
            default: nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/lnk_bringup_fsm.sv
module lnk_bringup_fsm
   import lnk_pkg::*;
#(
   parameter int unsigned ACQ_TIMEOUT = 64,
   parameter int unsigned DV_RUN      = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_det,
   input  logic       cdr_lock,
   input  logic       peer_ack,
   input  logic       train_done,
   input  logic       rsense_en,
   input  logic       dec_en,
   input  logic       data_valid,
   output logic [1:0] link_state,
   output logic       lock_n,
   output logic       lowpwr_req,
   output logic       peer_present
);
   generate
      if (ACQ_TIMEOUT <= DV_RUN + 1) begin : g_bad_window
         $error("lnk_bringup_fsm: ACQ_TIMEOUT must exceed DV_RUN + 1");
      end
   endgenerate

   lnk_state_t state_q, state_d;
   logic in_acq, acq_expired, run_met, train_ok;

   assign in_acq   = (state_q == ST_ACQUIRE);
   assign train_ok = train_done && (!dec_en || run_met);

   lnk_acq_timer #(.LIMIT(ACQ_TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_acq  (in_acq),
      .expired (acq_expired)
   );

   lnk_dv_qual #(.DV_RUN(DV_RUN)) u_dvq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_acq     (in_acq),
      .data_valid (data_valid),
      .run_met    (run_met)
   );

   lnk_next_state u_ns (
      .cur         (state_q),
      .sig_det     (sig_det),
      .cdr_lock    (cdr_lock),
      .peer_ack    (peer_ack),
      .rsense_en   (rsense_en),
      .train_ok    (train_ok),
      .acq_expired (acq_expired),
      .nxt         (state_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign link_state   = state_q;
   assign lock_n       = (state_q != ST_NORMAL);
   assign lowpwr_req   = (state_q == ST_IDLE);
   assign peer_present = rsense_en && (state_q != ST_IDLE);
endmodule

// File: rtl/lnk_bringup_chk.sv
module lnk_bringup_chk
   import lnk_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       sig_det,
   input logic       cdr_lock,
   input logic       peer_ack,
   input logic       train_done,
   input logic       rsense_en,
   input logic [1:0] link_state
);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == ST_IDLE && !sig_det) |=> (link_state == ST_IDLE));

   // R6
   sig_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state != ST_IDLE && !sig_det) |=> (link_state == ST_IDLE));

   // R4
   acq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == ST_ACQUIRE && $past(link_state) == ST_DETECT) |-> $past(peer_ack));

   // R5
   normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == ST_NORMAL && $past(link_state) == ST_ACQUIRE) |-> $past(train_done));

   // R7
   direct_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == ST_IDLE && !rsense_en && sig_det && cdr_lock) |=> (link_state == ST_NORMAL));
endmodule

bind lnk_bringup_fsm lnk_bringup_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sig_det    (sig_det),
   .cdr_lock   (cdr_lock),
   .peer_ack   (peer_ack),
   .train_done (train_done),
   .rsense_en  (rsense_en),
   .link_state (link_state)
);

// File: tb/lnk_bringup_fsm_tb.sv
module lnk_bringup_fsm_tb;
   localparam int unsigned TMO = 64;
   localparam int unsigned RUN = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sig_det = 0, cdr_lock = 0, peer_ack = 0, train_done = 0;
   logic rsense_en = 1, dec_en = 0, data_valid = 0;
   logic [1:0] link_state;
   logic lock_n, lowpwr_req, peer_present;
   int ntests = 0, nfail = 0;
   bit  done_flag = 0;

   always #5 clk = ~clk;

   lnk_bringup_fsm #(.ACQ_TIMEOUT(TMO), .DV_RUN(RUN)) u_dut (
      .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .cdr_lock(cdr_lock),
      .peer_ack(peer_ack), .train_done(train_done), .rsense_en(rsense_en),
      .dec_en(dec_en), .data_valid(data_valid), .link_state(link_state),
      .lock_n(lock_n), .lowpwr_req(lowpwr_req), .peer_present(peer_present)
   );

   // {sig_det, cdr_lock, peer_ack, train_done, rsense_en, dec_en, data_valid, expected state[1:0]}
   localparam logic [8:0] VEC [12] = '{
      9'b0000100_00,  // R3 no signal: stay IDLE
      9'b1000100_00,  // R3 signal without lock: stay IDLE
      9'b1100100_01,  // R3 signal + lock -> DETECT
      9'b1101100_01,  // R3/R4 train_done ignored, no ack: hold DETECT
      9'b1110100_10,  // R4 ack -> ACQUIRE
      9'b1100100_10,  // R5 waiting for pattern
      9'b1101100_11,  // R5 pattern complete -> NORMAL
      9'b1000100_01,  // R6 lock lost, signal present -> DETECT
      9'b1110100_10,  // R4 re-acquire
      9'b0100100_00,  // R6 signal lost -> IDLE
      9'b1100000_11,  // R7 handshake off: IDLE -> NORMAL
      9'b1000000_00   // R7 handshake off, lock lost -> IDLE
   };

   task automatic check_all(input logic [1:0] exp, input string req);
      logic [3:0] got, want;
      ntests++;
      got  = {link_state, lock_n, lowpwr_req};
      want = {exp, (exp != 2'd3), (exp == 2'd0)};
      if (got !== want || peer_present !== (rsense_en && exp != 2'd0)) begin
         nfail++;
         $display("FAIL %s state/lock_n/lowpwr/present actual=%b/%b expected=%b/%b",
                  req, got, peer_present, want, (rsense_en && exp != 2'd0));
      end
   endtask

   task automatic drive(input logic [6:0] v);
      {sig_det, cdr_lock, peer_ack, train_done, rsense_en, dec_en, data_valid} = v;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done_flag) begin
         ntests++; nfail++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin : main
      repeat (2) @(negedge clk);
      check_all(2'd0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VEC[i]) begin
         drive(VEC[i][8:2]);
         check_all(VEC[i][1:0], $sformatf("R2/R10 vector %0d", i));
      end

      // R9 timeout: reach ACQUIRE, never complete
      drive(7'b1100100);
      drive(7'b1110100);
      check_all(2'd2, "R9 entered ACQUIRE");
      for (int k = 1; k < TMO; k++) drive(7'b1100100);
      check_all(2'd2, "R9 still ACQUIRE one clock before timeout");
      drive(7'b1100100);
      check_all(2'd1, "R9 timeout -> DETECT");

      // R8 decoding: pattern done from entry, data_valid run needed
      drive(7'b1110110);
      check_all(2'd2, "R8 entered ACQUIRE");
      for (int k = 1; k < RUN; k++) drive(7'b1101111);
      drive(7'b1101111);
      check_all(2'd2, "R8 run incomplete after DV_RUN clocks");
      drive(7'b1101111);
      check_all(2'd3, "R8 NORMAL on clock DV_RUN+1");

      // R8 run broken: restart required
      drive(7'b1000110);
      drive(7'b1110110);
      for (int k = 0; k < RUN - 2; k++) drive(7'b1101111);
      drive(7'b1101110);
      for (int k = 0; k < RUN; k++) drive(7'b1101111);
      check_all(2'd2, "R8 dropped data_valid restarts run");
      drive(7'b1101111);
      check_all(2'd3, "R8 NORMAL after fresh run");

      // R1 asynchronous reset from NORMAL
      #2 rst_n = 1'b0;
      #1 check_all(2'd0, "R1 async reset from NORMAL");
      @(negedge clk);
      rst_n = 1'b1;
      drive(7'b0000100);
      check_all(2'd0, "R1 IDLE after release");

      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule